// File: doc/BRIEF.md
# Serial Clock-Calendar Register Access Slave

This block lets a host processor read and write a small byte-wide register file that holds the state of a real-time clock and calendar. The host talks to it over a four-wire serial peripheral link in mode 0: clock idle low, data sampled on the rising clock edge, 8-bit words with the most significant bit first. Each transaction opens with a command byte and a start-address byte. For a read command the block then shifts register contents out, one byte after another, from consecutive addresses. For a write command it stores every complete incoming data byte at consecutive addresses. A single transaction can therefore move a whole group of time fields, for example seconds through date, in one burst.

The same register file is shared with the timekeeping core through a parallel port. The core has one write port and one combinational read port. All other command values, including the storage, identity, watchdog and memory-clear commands of the surrounding device, are decoded as "no register access". The rest of such a transaction is clocked through and discarded. The serial pins are brought into the system clock domain by synchronizers, so the serial clock must run well below the system clock.

Top module: `rtcc_spi_slave`

## Requirements
- R1: Serial mode 0. MOSI is taken on each rising edge of SCK, most significant bit first. MISO changes only after a falling edge of SCK, so it is stable at the next rising edge.
- R2: Command 0x13 is a read. The next byte gives the start address. Each following byte slot returns, on MISO, the register at the current address, and the address then advances by one.
- R3: Command 0x12 is a write. The next byte gives the start address. Each following data byte is stored at the current address once all 8 of its bits have arrived, and the address then advances by one. Each stored byte produces exactly one single-cycle write into the register file.
- R4: The register file has 32 bytes. Only the low 5 bits of the address byte are used. The running address wraps from 0x1F to 0x00 in both reads and writes.
- R5: Every other command value, including 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x14, 0x32, 0x33, 0x44 and 0x54, causes no register access for the rest of the transaction, and MISO stays 0 throughout.
- R6: Deselecting (CS_n high) aborts the transaction. A partially received byte is not stored. The next selection starts again with a command byte at bit 0.
- R7: MISO is 0 while the block is deselected and during the command and address bytes.
- R8: The core port writes core_wdata to core_waddr when core_we is high. core_rdata always shows the register at core_raddr.
- R9: When a host write and a core write land in the same cycle at the same address, the host byte is kept. When they are at different addresses, both are stored.
- R10: After reset every register reads 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| core_we | input | 1 | Core write strobe |
| core_waddr | input | 5 | Core write address |
| core_wdata | input | 8 | Core write data |
| core_raddr | input | 5 | Core read address |
| core_rdata | output | 8 | Register contents at core_raddr |

## Verification
The bench targets the following corner cases:
- Burst reads and writes that cross the 0x1F to 0x00 boundary. A design that fails to wrap would lose or misplace the third byte.
- Every non-read, non-write command value followed by address-like and data-like bytes. A design that decodes these loosely would corrupt registers or drive data on MISO.
- A write aborted after five bits of a data byte. A design that commits early would store a partial byte, and one that keeps its counters would misframe the next transaction.
- A core write timed into the very cycle of the host commit, both at the same address and at a different address. This separates a design with the wrong priority from one that suppresses the core write globally.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_REG_READ  = 8'h13;
    localparam logic [BYTE_W-1:0] OP_REG_WRITE = 8'h12;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR_RD,
        PH_ADDR_WR,
        PH_READ,
        PH_WRITE,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/rtcc_pin_sync.sv
module rtcc_pin_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rtcc_frame.sv
module rtcc_frame
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso,
    output logic              hdr_phase,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [ADDR_W-1:0] ptr;
        logic              load_pend;
        logic              sck_prev;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } frame_t;

    frame_t s_d, s_q;
    logic sck_rise, sck_fall;
    logic [BYTE_W-1:0] byte_in;

    assign sck_rise = sck_s & ~s_q.sck_prev;
    assign sck_fall = ~sck_s & s_q.sck_prev;
    assign byte_in  = {s_q.rx[BYTE_W-2:0], mosi_s};

    always_comb begin
        s_d          = s_q;
        s_d.sck_prev = sck_s;
        s_d.wr_en    = 1'b0;
        if (cs_n_s) begin
            s_d          = '0;
            s_d.ph       = PH_CMD;
            s_d.sck_prev = sck_s;
        end else if (sck_rise) begin
            s_d.rx      = byte_in;
            s_d.bit_cnt = s_q.bit_cnt + 1'b1;
            if (s_q.bit_cnt == LAST_BIT) begin
                unique case (s_q.ph)
                    PH_CMD: begin
                        if (byte_in == OP_REG_READ)       s_d.ph = PH_ADDR_RD;
                        else if (byte_in == OP_REG_WRITE) s_d.ph = PH_ADDR_WR;
                        else                              s_d.ph = PH_SKIP;
                    end
                    PH_ADDR_RD: begin
                        s_d.ptr       = byte_in[ADDR_W-1:0];
                        s_d.load_pend = 1'b1;
                        s_d.ph        = PH_READ;
                    end
                    PH_ADDR_WR: begin
                        s_d.ptr = byte_in[ADDR_W-1:0];
                        s_d.ph  = PH_WRITE;
                    end
                    PH_READ: s_d.load_pend = 1'b1;
                    PH_WRITE: begin
                        s_d.wr_en   = 1'b1;
                        s_d.wr_addr = s_q.ptr;
                        s_d.wr_data = byte_in;
                        s_d.ptr     = s_q.ptr + 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall) begin
            if (s_q.load_pend) begin
                s_d.tx        = rd_data;
                s_d.ptr       = s_q.ptr + 1'b1;
                s_d.load_pend = 1'b0;
            end else begin
                s_d.tx = {s_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_CMD;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_addr   = s_q.ptr;
    assign miso      = s_q.tx[BYTE_W-1];
    assign hdr_phase = (s_q.ph == PH_CMD) || (s_q.ph == PH_ADDR_RD) || (s_q.ph == PH_ADDR_WR);
    assign wr_en     = s_q.wr_en;
    assign wr_addr   = s_q.wr_addr;
    assign wr_data   = s_q.wr_data;
endmodule

// File: rtl/rtcc_regfile.sv
module rtcc_regfile
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_waddr,
    input  logic [BYTE_W-1:0] core_wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] core_raddr,
    output logic [BYTE_W-1:0] core_rdata
);
    localparam int NREG = 2 ** ADDR_W;

    logic [BYTE_W-1:0] mem_d [NREG];
    logic [BYTE_W-1:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (core_we) mem_d[core_waddr] = core_wdata;
        if (host_we) mem_d[host_addr]  = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign host_rdata = mem_q[host_raddr];
    assign core_rdata = mem_q[core_raddr];
endmodule

// File: rtl/rtcc_spi_slave.sv
module rtcc_spi_slave
    import rtcc_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_waddr,
    input  logic [BYTE_W-1:0] core_wdata,
    input  logic [ADDR_W-1:0] core_raddr,
    output logic [BYTE_W-1:0] core_rdata
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_n_s, mosi_s;
    logic              hdr_phase;
    logic              host_we;
    logic [ADDR_W-1:0] host_addr;
    logic [BYTE_W-1:0] host_wdata;
    logic [ADDR_W-1:0] host_raddr;
    logic [BYTE_W-1:0] host_rdata;

    rtcc_pin_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST    (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_mosi, spi_cs_n, spi_sck}),
        .dout  (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[2];

    rtcc_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .rd_data   (host_rdata),
        .rd_addr   (host_raddr),
        .miso      (spi_miso),
        .hdr_phase (hdr_phase),
        .wr_en     (host_we),
        .wr_addr   (host_addr),
        .wr_data   (host_wdata)
    );

    rtcc_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .core_we    (core_we),
        .core_waddr (core_waddr),
        .core_wdata (core_wdata),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .core_raddr (core_raddr),
        .core_rdata (core_rdata)
    );
endmodule

// File: rtl/rtcc_spi_slave_chk.sv
module rtcc_spi_slave_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              hdr_phase,
    input logic              spi_miso,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              core_we,
    input logic [ADDR_W-1:0] core_waddr,
    input logic [7:0]        core_wdata,
    input logic [ADDR_W-1:0] core_raddr,
    input logic [7:0]        core_rdata
);
    p_miso_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !spi_miso);

    p_hdr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_phase |-> !spi_miso);

    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> !host_we);

    p_host_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && core_we && core_waddr == host_addr && core_raddr == host_addr)
        |=> (!$stable(core_raddr) || core_rdata == $past(host_wdata)));

    p_core_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && !(host_we && host_addr == core_waddr) && core_raddr == core_waddr)
        |=> (!$stable(core_raddr) || core_rdata == $past(core_wdata)));
endmodule

bind rtcc_spi_slave rtcc_spi_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .hdr_phase  (hdr_phase),
    .spi_miso   (spi_miso),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .core_we    (core_we),
    .core_waddr (core_waddr),
    .core_wdata (core_wdata),
    .core_raddr (core_raddr),
    .core_rdata (core_rdata)
);

// File: tb/rtcc_spi_slave_tb_top.sv
`timescale 1ns/1ps
module rtcc_spi_slave_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       core_we = 1'b0;
    logic [4:0] core_waddr = '0;
    logic [7:0] core_wdata = '0;
    logic [4:0] core_raddr = '0;
    logic [7:0] core_rdata;

    int total = 0;
    int bad = 0;
    bit quiet = 1'b0;
    bit miso_zero = 1'b0;
    logic [7:0] model [32];
    logic [7:0] rxb [16];
    logic [7:0] txb [16];

    always #2.5 clk = ~clk;

    rtcc_spi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_we(core_we),
        .core_waddr(core_waddr), .core_wdata(core_wdata),
        .core_raddr(core_raddr), .core_rdata(core_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        #1;
        if (quiet) chk("R8 R10 core read vs model", core_rdata, model[core_raddr]);
        if (quiet) chk("R7 miso while deselected", spi_miso, 0);
        if (miso_zero) chk("R5 R7 miso held low", spi_miso, 0);
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                            input bit collide, input int nbits);
        for (int i = 7; i >= 8 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            if (collide && i == 0) begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                core_we = 1'b1;
                @(negedge clk);
                core_we = 1'b0;
                repeat (HALF - 4) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            spi_sck = 1'b0;
        end
    endtask

    task automatic select();
        quiet = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic deselect();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        miso_zero = 1'b0;
        repeat (HALF) @(negedge clk);
        quiet = 1'b1;
    endtask

    // one full transaction: command, address, n data bytes
    task automatic txn(input logic [7:0] op, input logic [7:0] addr, input int n,
                       input bit zero_all, input int collide_at);
        logic [7:0] r;
        select();
        miso_zero = 1'b1;
        spi_byte(op, r, 1'b0, 8);
        spi_byte(addr, r, 1'b0, 8);
        miso_zero = zero_all;
        for (int k = 0; k < n; k++) begin
            spi_byte(txb[k], r, (k == collide_at), 8);
            rxb[k] = r;
        end
        deselect();
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            core_raddr = a[4:0];
            #1 chk(tag, core_rdata, model[a]);
        end
    endtask

    initial begin
        logic [7:0] ign [11];
        logic [7:0] r;
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        quiet = 1'b1;
        chk("R10 miso after reset", spi_miso, 0);
        sweep("R10 registers zero after reset");

        // R3: burst write of five bytes from 0x01
        for (int k = 0; k < 5; k++) txb[k] = 8'h10 + 8'(k * 17);
        txn(8'h12, 8'h01, 5, 1'b0, -1);
        for (int k = 0; k < 5; k++) model[1 + k] = 8'h10 + 8'(k * 17);
        sweep("R3 burst write from 0x01");

        // R2 R1: burst read of the same range, plus one beyond
        for (int k = 0; k < 6; k++) txb[k] = 8'hFF;
        txn(8'h13, 8'h01, 6, 1'b0, -1);
        for (int k = 0; k < 6; k++) chk("R2 R1 burst read byte", rxb[k], model[1 + k]);

        // R4: write wrapping 0x1E -> 0x1F -> 0x00, upper address bits ignored
        txb[0] = 8'hA1; txb[1] = 8'hB2; txb[2] = 8'hC3;
        txn(8'h12, 8'hFE, 3, 1'b0, -1);
        model[30] = 8'hA1; model[31] = 8'hB2; model[0] = 8'hC3;
        sweep("R4 write wraps at top");

        // R4 R2: read wrapping from 0x1D
        txn(8'h13, 8'h1D, 6, 1'b0, -1);
        for (int k = 0; k < 6; k++) chk("R4 read wraps", rxb[k], model[(29 + k) % 32]);

        // R5: other commands do nothing and keep miso low
        ign = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h14, 8'h32, 8'h33, 8'h44, 8'h54};
        foreach (ign[j]) begin
            txb[0] = 8'h5A; txb[1] = 8'h77;
            txn(ign[j], 8'h01, 2, 1'b1, -1);
            chk("R5 ignored command miso", rxb[0] | rxb[1], 0);
        end
        txb[0] = 8'h99;
        txn(8'hFF, 8'h02, 1, 1'b1, -1);
        sweep("R5 registers untouched by other commands");

        // R6: abort inside a data byte
        select();
        spi_byte(8'h12, r, 1'b0, 8);
        spi_byte(8'h04, r, 1'b0, 8);
        spi_byte(8'hFF, r, 1'b0, 5);
        deselect();
        sweep("R6 partial byte not stored");
        txb[0] = 8'h3E;
        txn(8'h12, 8'h04, 1, 1'b0, -1);
        model[4] = 8'h3E;
        txn(8'h13, 8'h04, 1, 1'b0, -1);
        chk("R6 fresh transaction after abort", rxb[0], 8'h3E);

        // R8: core port write alone
        quiet = 1'b0;
        @(negedge clk);
        core_waddr = 5'd20; core_wdata = 8'h6D; core_we = 1'b1;
        @(negedge clk);
        core_we = 1'b0;
        model[20] = 8'h6D;
        @(negedge clk);
        quiet = 1'b1;
        txn(8'h13, 8'h14, 1, 1'b0, -1);
        chk("R8 core write seen by host read", rxb[0], 8'h6D);

        // R9: same-address collision, host wins
        core_waddr = 5'd9; core_wdata = 8'hC3;
        txb[0] = 8'h3C;
        txn(8'h12, 8'h09, 1, 1'b0, 0);
        model[9] = 8'h3C;
        core_raddr = 5'd9;
        @(negedge clk);
        #1 chk("R9 host wins same address", core_rdata, 8'h3C);

        // R9: different-address collision, both kept
        core_waddr = 5'd10; core_wdata = 8'h77;
        txb[0] = 8'h5A;
        txn(8'h12, 8'h09, 1, 1'b0, 0);
        model[9] = 8'h5A; model[10] = 8'h77;
        sweep("R9 both writes kept at different addresses");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule